// File: doc/BRIEF.md
# PCM Transmit Output-Enable Supervisor

This block sits between the serial port of a PCM voice interface and the tri-state driver of its transmit line. The serial port asks for the line whenever its own time slot is active. The supervisor passes that request on only when the interface is in a trustworthy condition. After reset, it holds the line at high impedance through a quiet window of whole frames. It also drops the line on its own when the bit clock stops. Every input is sampled by a free-running reference clock. The bit clock, the channel-0 frame sync and the reset pin are brought in through two-stage synchronisers. The slot request is assumed to be already synchronous to the reference clock.

The quiet window opens when the first channel-0 frame sync is recognised. Recognition means the sync is high when the bit clock falls. From that point the window counts complete frames of `BITS_PER_FRAME` bit-clock falls. The line becomes usable after `QUIET_FRAMES` frames have been counted. A watchdog running on the reference clock declares the bit clock lost when it sees no bit-clock edge for `LOSS_CYCLES` reference cycles. The default is 4000 cycles, which is 20 µs at 200 MHz. When the clock comes back, the whole quiet window is run again. The active-high reset pin is qualified: it takes effect only after it has been held through `RST_HOLD` bit-clock falls. While it is held past that point, it keeps the block in its start-up state.

Top module: `pcm_oe_supervisor`

## Requirements
- R1: While `rst_n` is low and right after it rises, `pcm_oe` is 0 and `sup_status` is 2'b00 (start-up). Status encoding is 2'b00 start-up, 2'b01 running, 2'b10 clock lost.
- R2: In the running state, `pcm_oe` equals `slot_oe_req` in the same cycle. In every other state, `pcm_oe` is 0 whatever the request.
- R3: The block stays in start-up, with `pcm_oe` at 0, for as long as no channel-0 sync recognition occurs. A recognition is `fs_ch0` high at a falling edge of `bit_clk`.
- R4: After a recognition, the state becomes running only after `QUIET_FRAMES*BITS_PER_FRAME` further bit-clock falls (default 1024). It becomes running no later than 5 reference cycles after that last fall reaches the pin.
- R5: If `bit_clk` shows no edge for `LOSS_CYCLES` reference cycles, the state becomes clock lost and `pcm_oe` is 0. The state is not lost while edges keep arriving.
- R6: The first bit-clock edge seen in the clock-lost state returns the block to start-up. The full quiet window of R4 then applies again from a fresh recognition.
- R7: A high pulse on `rst_pin` that spans fewer than `RST_HOLD` bit-clock falls (default 64) leaves a running block running.
- R8: Holding `rst_pin` high through more than `RST_HOLD` bit-clock falls returns the block to start-up with `pcm_oe` at 0. After release, a fresh recognition and a full quiet window are needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rst_pin | input | 1 | Active-high external reset request, qualified by hold time |
| bit_clk | input | 1 | PCM bit clock (asynchronous, sampled) |
| fs_ch0 | input | 1 | Channel-0 frame sync (asynchronous, sampled) |
| slot_oe_req | input | 1 | Slot-level drive request from the serial port |
| pcm_oe | output | 1 | Final tri-state enable of the transmit line |
| sup_status | output | 2 | 00 start-up, 01 running, 10 clock lost |

## Verification
The slot request is driven with random values on every cycle in every phase. The same random traffic therefore shows both that the request passes through in the running state and that it is blocked in start-up and clock-lost states. The quiet window is checked on both sides of its last bit-clock fall, one fall early and one fall late. This separates a correct frame count from an off-by-one or a count that starts before the recognition. A stopped bit clock is checked 20 cycles before and 20 cycles after the loss limit, and then followed by a restart. Reset-pin pulses of 40 and 70 falls fall on either side of the hold threshold.

// File: rtl/pcm_oe_pkg.sv
package pcm_oe_pkg;
  typedef enum logic [1:0] {
    SUP_START = 2'b00,
    SUP_RUN   = 2'b01,
    SUP_LOST  = 2'b10
  } sup_state_e;
endpackage

// File: rtl/pcm_sync_edge.sv
// Two-stage synchroniser per bit plus one history stage for edge detection.
module pcm_sync_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic [2:0] sh_q;
      logic [2:0] sh_d;
      always_comb sh_d = {sh_q[1:0], d[i]};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
      end
      assign q[i]    = sh_q[1];
      assign rise[i] = sh_q[1] & ~sh_q[2];
      assign fall[i] = ~sh_q[1] & sh_q[2];
    end
  endgenerate
endmodule

// File: rtl/pcm_clk_watch.sv
// Reference-cycle timer cleared by every synchronised bit-clock edge.
module pcm_clk_watch #(
  parameter int LOSS_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_seen,
  output logic lost
);
  localparam int CW = $clog2(LOSS_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOSS_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = edge_seen || (cnt_q != LIMIT);
    cnt_d  = edge_seen ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign lost = (cnt_q == LIMIT);
endmodule

// File: rtl/pcm_frame_timer.sv
// Counts whole frames of bit-clock falls after the first channel-0 recognition.
module pcm_frame_timer #(
  parameter int BITS_PER_FRAME = 256,
  parameter int QUIET_FRAMES   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic arm,
  input  logic tick,
  output logic done
);
  localparam int BW = (BITS_PER_FRAME > 1) ? $clog2(BITS_PER_FRAME) : 1;
  localparam int FW = $clog2(QUIET_FRAMES + 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(BITS_PER_FRAME - 1);
  localparam logic [FW-1:0] FRM_DONE = FW'(QUIET_FRAMES);

  logic          armed_q, armed_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [FW-1:0] frm_q, frm_d;

  assign done = armed_q && (frm_q == FRM_DONE);

  always_comb begin
    armed_d = armed_q;
    bit_d   = bit_q;
    frm_d   = frm_q;
    if (clr) begin
      armed_d = 1'b0;
      bit_d   = '0;
      frm_d   = '0;
    end else if (!armed_q) begin
      if (arm) begin
        armed_d = 1'b1;
        bit_d   = '0;
        frm_d   = '0;
      end
    end else if (tick && !done) begin
      if (bit_q == BIT_LAST) begin
        bit_d = '0;
        frm_d = frm_q + 1'b1;
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      bit_q   <= '0;
      frm_q   <= '0;
    end else begin
      armed_q <= armed_d;
      bit_q   <= bit_d;
      frm_q   <= frm_d;
    end
  end
endmodule

// File: rtl/pcm_rst_qual.sv
// Reset pin takes effect only after being held through HOLD_TICKS bit-clock falls.
module pcm_rst_qual #(
  parameter int HOLD_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic tick,
  output logic active
);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [HW-1:0] HOLD = HW'(HOLD_TICKS);

  logic [HW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign active = (cnt_q == HOLD);

  always_comb begin
    cnt_en = !pin || (tick && !active);
    cnt_d  = pin ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pcm_oe_supervisor.sv
module pcm_oe_supervisor
  import pcm_oe_pkg::*;
#(
  parameter int BITS_PER_FRAME = 256,
  parameter int QUIET_FRAMES   = 4,
  parameter int LOSS_CYCLES    = 4000,
  parameter int RST_HOLD       = 64
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       rst_pin,
  input  logic       bit_clk,
  input  logic       fs_ch0,
  input  logic       slot_oe_req,
  output logic       pcm_oe,
  output logic [1:0] sup_status
);
  localparam int N_SYNC = 3;
  localparam int I_BCK  = 0;
  localparam int I_FS   = 1;
  localparam int I_RST  = 2;

  logic [N_SYNC-1:0] s_lvl, s_rise, s_fall;
  logic bck_fall, bck_edge, recog, lost, warm_done, rst_hold, tmr_clr;
  sup_state_e st_q, st_d;

  pcm_sync_edge #(.W(N_SYNC)) u_sync (
    .clk(ref_clk), .rst_n(rst_n), .d({rst_pin, fs_ch0, bit_clk}),
    .q(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  assign bck_fall = s_fall[I_BCK];
  assign bck_edge = s_fall[I_BCK] | s_rise[I_BCK];
  assign recog    = bck_fall & s_lvl[I_FS];

  pcm_clk_watch #(.LOSS_CYCLES(LOSS_CYCLES)) u_watch (
    .clk(ref_clk), .rst_n(rst_n), .edge_seen(bck_edge), .lost(lost)
  );

  pcm_rst_qual #(.HOLD_TICKS(RST_HOLD)) u_rstq (
    .clk(ref_clk), .rst_n(rst_n), .pin(s_lvl[I_RST]), .tick(bck_fall),
    .active(rst_hold)
  );

  assign tmr_clr = (st_q != SUP_START) || rst_hold || lost;

  pcm_frame_timer #(
    .BITS_PER_FRAME(BITS_PER_FRAME), .QUIET_FRAMES(QUIET_FRAMES)
  ) u_tmr (
    .clk(ref_clk), .rst_n(rst_n), .clr(tmr_clr), .arm(recog),
    .tick(bck_fall), .done(warm_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SUP_START: if (lost) st_d = SUP_LOST; else if (warm_done) st_d = SUP_RUN;
      SUP_RUN:   if (lost) st_d = SUP_LOST;
      SUP_LOST:  if (bck_edge) st_d = SUP_START;
      default:   st_d = SUP_START;
    endcase
    if (rst_hold) st_d = SUP_START;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) st_q <= SUP_START;
    else        st_q <= st_d;
  end

  assign pcm_oe     = slot_oe_req && (st_q == SUP_RUN);
  assign sup_status = st_q;
endmodule

// File: rtl/pcm_oe_supervisor_chk.sv
module pcm_oe_supervisor_chk #(
  parameter int LOSS_CYCLES = 4000
) (
  input logic       ref_clk,
  input logic       rst_n,
  input logic       rst_pin,
  input logic       bit_clk,
  input logic       pcm_oe,
  input logic [1:0] sup_status
);
  localparam int CW = $clog2(LOSS_CYCLES + 2);
  localparam logic [CW-1:0] SAT = CW'(LOSS_CYCLES + 1);

  logic          prev_bck;
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_bck <= 1'b0;
      idle_cnt <= '0;
    end else begin
      prev_bck <= bit_clk;
      if (bit_clk != prev_bck) idle_cnt <= '0;
      else if (idle_cnt != SAT) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  // R5
  loss_after_timeout_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(sup_status == 2'b10) |-> (idle_cnt >= CW'(LOSS_CYCLES)));

  // R6
  no_direct_resume_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (sup_status == 2'b10) |=> (sup_status != 2'b01));

  // R4
  run_from_start_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(sup_status == 2'b01) |-> ($past(sup_status) == 2'b00));

  // R2
  oe_only_running_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pcm_oe |-> (sup_status == 2'b01));

  // R7
  run_kept_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ((sup_status == 2'b01) && !rst_pin && !$past(rst_pin) && !$past(rst_pin, 2)
     && !$past(rst_pin, 3) && (idle_cnt < CW'(LOSS_CYCLES / 2)))
    |=> (sup_status == 2'b01));
endmodule

bind pcm_oe_supervisor pcm_oe_supervisor_chk #(.LOSS_CYCLES(LOSS_CYCLES)) u_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .rst_pin(rst_pin), .bit_clk(bit_clk),
  .pcm_oe(pcm_oe), .sup_status(sup_status)
);

// File: tb/pcm_oe_supervisor_test.sv
`timescale 1ns/1ps
module pcm_oe_supervisor_test;
  localparam int LOSS = 4000;
  localparam int WARM = 4 * 256;

  logic clk = 1'b0, rst_n = 1'b0, rst_pin = 1'b0, bclk = 1'b0, fs = 1'b0, req = 1'b0;
  logic oe;
  logic [1:0] st;
  logic bclk_run = 1'b0, fs_en = 1'b0, done = 1'b0;
  int   div = 0, fall_cnt = 0, n_chk = 0, n_bad = 0;
  logic [7:0] pos = 8'd0;

  always #2.5 clk = ~clk;

  pcm_oe_supervisor uut (
    .ref_clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .bit_clk(bclk),
    .fs_ch0(fs), .slot_oe_req(req), .pcm_oe(oe), .sup_status(st)
  );

  // bit clock = ref/8, channel-0 sync high for one bit period every 256 bits
  always @(posedge clk) begin
    if (bclk_run) begin
      if (div == 3) begin
        div  <= 0;
        bclk <= ~bclk;
        if (bclk) fall_cnt <= fall_cnt + 1;
        else begin
          pos <= pos + 8'd1;
          fs  <= fs_en && (pos == 8'd255);
        end
      end else div <= div + 1;
    end
  end

  function automatic logic exp_oe(input logic r, input int mode);
    return (mode == 1) ? r : 1'b0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // mode 0: oe must be 0, mode 1: oe follows req, mode 2: no oe check
  task automatic step(input int mode, input string tag);
    @(negedge clk);
    if (mode != 2) chk(tag, {31'd0, oe}, {31'd0, exp_oe(req, mode)});
    req = 1'($urandom);
  endtask

  task automatic wait_fall(input int mode, input string tag);
    int c = fall_cnt;
    while (fall_cnt == c) step(mode, tag);
  endtask

  task automatic falls(input int n, input int mode, input string tag);
    for (int i = 0; i < n; i++) wait_fall(mode, tag);
  endtask

  task automatic warm_up(input string tag);
    do wait_fall(0, tag); while (fs !== 1'b1);
    falls(WARM - 1, 0, tag);
    step(2, tag); step(2, tag);
    chk({tag, " one fall early"}, {30'd0, st}, 32'd0);
    wait_fall(2, tag);
    for (int i = 0; i < 5; i++) step(2, tag);
    chk({tag, " after window"}, {30'd0, st}, 32'd1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk("R1 status in reset", {30'd0, st}, 32'd0);
    req = 1'b1; #1;
    chk("R1 oe in reset", {31'd0, oe}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", {30'd0, st}, 32'd0);

    bclk_run = 1'b1;
    falls(300, 0, "R3 no sync");
    chk("R3 still start-up", {30'd0, st}, 32'd0);

    fs_en = 1'b1;
    warm_up("R4");
    falls(400, 1, "R2 running traffic");

    wait_fall(1, "R2");
    bclk_run = 1'b0;
    for (int i = 0; i < LOSS - 20; i++) step(1, "R5 before limit");
    chk("R5 not lost early", {30'd0, st}, 32'd1);
    for (int i = 0; i < 40; i++) step(2, "R5");
    chk("R5 lost", {30'd0, st}, 32'd2);
    for (int i = 0; i < 50; i++) step(0, "R5 lost oe");

    bclk_run = 1'b1;
    for (int i = 0; i < 12; i++) step(2, "R6");
    chk("R6 back to start-up", {30'd0, st}, 32'd0);
    warm_up("R6");

    wait_fall(1, "R7");
    rst_pin = 1'b1;
    falls(40, 1, "R7 short pulse");
    rst_pin = 1'b0;
    falls(10, 1, "R7 after pulse");
    chk("R7 still running", {30'd0, st}, 32'd1);

    rst_pin = 1'b1;
    falls(70, 2, "R8");
    chk("R8 start-up while held", {30'd0, st}, 32'd0);
    falls(20, 0, "R8 held oe");
    rst_pin = 1'b0;
    warm_up("R8");

    falls(300, 1, "R2 random tail");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule